// File: doc/BRIEF.md
# Framebuffer 2D Window Fetch Address Generator

This block produces the word addresses a display engine uses to read a rectangular visible window out of a larger virtual framebuffer. Each visible line is a run of consecutive 32-bit words. At the end of every line the address jumps over the part of the virtual line that is not shown. After the programmed number of words in a frame it returns to the frame base. Reads are issued as fixed-length bursts over a request/acknowledge interface. A new burst is requested only when the occupancy of the downstream line FIFO falls below a threshold. After the acknowledge, the block presents one word address per cycle for the beats of the burst.

Configuration is double-buffered. A strobe captures base address, line length, frame length, line skip and the sub-word pixel bit offset into a shadow copy. The shadow copy becomes active only at the next frame start, either a start from idle or a wrap. Software can therefore retarget the fetch (panning, page flipping) without stopping it. A busy output shows that a frame fetch is running. When the enable is withdrawn, the block finishes the frame, completes the burst holding the frame's last word and then goes idle.

The controller has four states:
- `ST_IDLE`: nothing is fetched.
- `ST_WAIT`: waits for FIFO room.
- `ST_REQ`: holds the burst request.
- `ST_BEAT`: steps through the burst words.

It has these transitions:
- `start`: IDLE to WAIT, taken when enable is high.
- `room`: WAIT to REQ.
- `grant`: REQ to BEAT, taken on acknowledge.
- `burst_done`: BEAT to WAIT.
- `stop`: BEAT to IDLE, taken after the burst that held a frame end while enable was low.

Top module: `fb2d_fetch`

## Requirements
- R1: After reset, `busy`, `bus_req`, `beat_valid` and `sof` are 0 and `pix_off` is 0.
- R2: When `enable` is high in idle, the next cycle shows `busy`=1 and `sof`=1, and the first word address is the active base with bits [1:0] forced to 0.
- R3: A burst request rises only if, in the cycle before, `fifo_level` was below FIFO_DEPTH − (2·BURST + 3) (493 for the defaults) and the FIFO had room for BURST words.
- R4: `bus_req` stays high with a stable `bus_addr` until `bus_ack`, and `bus_len` carries BURST − 1 (7).
- R5: The cycle after an acknowledge, `beat_valid` rises. It stays high for exactly BURST cycles with one word address per cycle, and addresses step by 4 inside a line. `bus_addr` equals the burst's first word address.
- R6: After the last word of a visible line (line length counted in words), the next address is (address + 4 + skip bytes) rounded down to a multiple of 4.
- R7: After the frame's last word (frame length counted in words), the next address is the base with bits [1:0] cleared. `sof` pulses for one cycle right after that beat.
- R8: `cfg_update` captures base, line length, frame length, skip and pixel offset into a shadow copy. The active copy, including `pix_off`, changes only at the next frame start (start from idle or wrap).
- R9: `busy` is high from start until stop, and `bus_req`/`beat_valid` are 0 while it is low. With `enable` low, the block stops after the burst that contains a frame's last word, and `busy` is 0 the cycle after that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request; low stops at the next frame end |
| cfg_update | input | 1 | Capture the cfg_* values into the shadow copy |
| cfg_base | input | ADDR_W | Frame base byte address (bits [1:0] ignored) |
| cfg_line_words | input | LINE_W | Visible words per line |
| cfg_frame_words | input | FRAME_W | Words per frame |
| cfg_skip | input | SKIP_W | Bytes skipped after each visible line |
| cfg_pix_off | input | 5 | Bit position of the first pixel in the first word |
| fifo_level | input | LVL_W | Current line FIFO occupancy in words |
| bus_req | output | 1 | Burst read request |
| bus_addr | output | ADDR_W | First word address of the requested burst |
| bus_len | output | LEN_W | Burst length minus one |
| bus_ack | input | 1 | Burst request accepted |
| beat_valid | output | 1 | A burst word address is presented |
| beat_addr | output | ADDR_W | Word address of the current beat |
| sof | output | 1 | One-cycle start-of-frame pulse |
| pix_off | output | 5 | Active first-pixel bit offset |
| busy | output | 1 | Frame fetch in progress |

## Verification
A corrupted word, line or frame counter shows up as a wrong `beat_addr` on the very next beat. A missed line end or wrap therefore appears within one burst, not one frame later. A shadow copy applied at the wrong time shows as a `pix_off` change or a base jump without an `sof` pulse in the same cycle. A bad burst counter shows as a beat train that is not BURST long. A stuck stop flag shows as `busy` still high the cycle after the burst that holds the frame end. The bench compares every beat address against an independent walk of the window. It does this under random line and frame shapes, random FIFO levels and random acknowledge delays, and it applies mid-frame configuration updates.

// File: rtl/fb2d_pkg.sv
package fb2d_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_REQ,
        ST_BEAT
    } fetch_st_t;
endpackage

// File: rtl/fb2d_shadow.sv
module fb2d_shadow #(
    parameter int ADDR_W  = 32,
    parameter int LINE_W  = 12,
    parameter int FRAME_W = 20,
    parameter int SKIP_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd,
    input  logic               apply,
    input  logic [ADDR_W-1:0]  in_base,
    input  logic [LINE_W-1:0]  in_line,
    input  logic [FRAME_W-1:0] in_frame,
    input  logic [SKIP_W-1:0]  in_skip,
    input  logic [4:0]         in_off,
    output logic [ADDR_W-1:0]  act_base,
    output logic [LINE_W-1:0]  act_line,
    output logic [FRAME_W-1:0] act_frame,
    output logic [SKIP_W-1:0]  act_skip,
    output logic [4:0]         act_off,
    output logic [ADDR_W-1:0]  nxt_base
);
    logic [ADDR_W-1:0]  sh_base;
    logic [LINE_W-1:0]  sh_line;
    logic [FRAME_W-1:0] sh_frame;
    logic [SKIP_W-1:0]  sh_skip;
    logic [4:0]         sh_off;
    logic               pend;

    // base that a frame start in this cycle will use
    assign nxt_base = pend ? sh_base : act_base;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_base  <= '0;
            sh_line  <= '0;
            sh_frame <= '0;
            sh_skip  <= '0;
            sh_off   <= '0;
            pend     <= 1'b0;
        end else begin
            if (upd) begin
                sh_base  <= in_base;
                sh_line  <= in_line;
                sh_frame <= in_frame;
                sh_skip  <= in_skip;
                sh_off   <= in_off;
            end
            pend <= upd | (pend & ~apply);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_base  <= '0;
            act_line  <= '0;
            act_frame <= '0;
            act_skip  <= '0;
            act_off   <= '0;
        end else if (apply && pend) begin
            act_base  <= sh_base;
            act_line  <= sh_line;
            act_frame <= sh_frame;
            act_skip  <= sh_skip;
            act_off   <= sh_off;
        end
    end

    // R8: the active copy moves only on a frame-start apply
    p_act_only_on_apply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_base) |-> $past(apply));
endmodule

// File: rtl/fb2d_walker.sv
module fb2d_walker #(
    parameter int ADDR_W  = 32,
    parameter int LINE_W  = 12,
    parameter int FRAME_W = 20,
    parameter int SKIP_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               step,
    input  logic [ADDR_W-1:0]  base_nxt,
    input  logic [LINE_W-1:0]  line_words,
    input  logic [FRAME_W-1:0] frame_words,
    input  logic [SKIP_W-1:0]  skip,
    output logic [ADDR_W-1:0]  addr,
    output logic               last_word
);
    localparam logic [ADDR_W-1:0] WMASK = ~ADDR_W'(3);
    localparam logic [ADDR_W-1:0] WSTEP = ADDR_W'(4);

    logic [LINE_W-1:0]  lcnt;
    logic [FRAME_W-1:0] fcnt;
    logic               line_last;
    logic [ADDR_W-1:0]  skip_addr;

    assign last_word = (fcnt == frame_words - FRAME_W'(1));
    assign line_last = (lcnt == line_words - LINE_W'(1));
    assign skip_addr = (addr + WSTEP + ADDR_W'(skip)) & WMASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
            lcnt <= '0;
            fcnt <= '0;
        end else if (restart || (step && last_word)) begin
            addr <= base_nxt & WMASK;
            lcnt <= '0;
            fcnt <= '0;
        end else if (step) begin
            fcnt <= fcnt + FRAME_W'(1);
            if (line_last) begin
                addr <= skip_addr;
                lcnt <= '0;
            end else begin
                addr <= addr + WSTEP;
                lcnt <= lcnt + LINE_W'(1);
            end
        end
    end

    // R5: a mid-line step is one word forward
    p_word_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart && !last_word && !line_last) |=> addr == $past(addr) + WSTEP);
endmodule

// File: rtl/fb2d_burst_fsm.sv
module fb2d_burst_fsm
    import fb2d_pkg::*;
#(
    parameter int BURST      = 8,
    parameter int FIFO_DEPTH = 512,
    parameter int LVL_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             bus_ack,
    input  logic             last_word,
    output logic             bus_req,
    output logic             beat_valid,
    output logic             step,
    output logic             restart,
    output logic             busy,
    output logic             frame_wrap
);
    localparam int THRESH = FIFO_DEPTH - (2 * BURST + 3);
    localparam int BCNT_W = (BURST > 1) ? $clog2(BURST) : 1;

    fetch_st_t         st, st_nx;
    logic [BCNT_W-1:0] bcnt;
    logic              stopping;
    logic              room;
    logic              last_beat;
    logic              stop_now;

    assign room = (fifo_level < LVL_W'(THRESH)) &&
                  (((LVL_W+1)'(FIFO_DEPTH) - {1'b0, fifo_level}) >= (LVL_W+1)'(BURST));
    assign last_beat  = (bcnt == BCNT_W'(BURST - 1));
    assign frame_wrap = (st == ST_BEAT) && last_word;
    assign stop_now   = stopping | (frame_wrap & ~enable);

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (enable)    st_nx = ST_WAIT;
            ST_WAIT: if (room)      st_nx = ST_REQ;
            ST_REQ:  if (bus_ack)   st_nx = ST_BEAT;
            ST_BEAT: if (last_beat) st_nx = stop_now ? ST_IDLE : ST_WAIT;
            default:                st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            bcnt     <= '0;
            stopping <= 1'b0;
        end else begin
            st <= st_nx;
            if (st == ST_BEAT && !last_beat) bcnt <= bcnt + BCNT_W'(1);
            else                             bcnt <= '0;
            if (st_nx == ST_IDLE)            stopping <= 1'b0;
            else if (frame_wrap && !enable)  stopping <= 1'b1;
        end
    end

    always_comb begin
        bus_req    = 1'b0;
        beat_valid = 1'b0;
        step       = 1'b0;
        restart    = 1'b0;
        busy       = 1'b1;
        unique case (st)
            ST_IDLE: begin
                busy    = 1'b0;
                restart = enable;
            end
            ST_WAIT: ;
            ST_REQ:  bus_req = 1'b1;
            ST_BEAT: begin
                beat_valid = 1'b1;
                step       = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    // R3: requests only follow a FIFO level below the threshold
    p_req_thresh_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(fifo_level) < LVL_W'(THRESH));
    // R9: an idle block drives no bus activity
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_req && !beat_valid));
endmodule

// File: rtl/fb2d_fetch.sv
module fb2d_fetch #(
    parameter int ADDR_W     = 32,
    parameter int LINE_W     = 12,
    parameter int FRAME_W    = 20,
    parameter int SKIP_W     = 16,
    parameter int BURST      = 8,
    parameter int FIFO_DEPTH = 512,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1),
    parameter int LEN_W      = (BURST > 1) ? $clog2(BURST) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               cfg_update,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [LINE_W-1:0]  cfg_line_words,
    input  logic [FRAME_W-1:0] cfg_frame_words,
    input  logic [SKIP_W-1:0]  cfg_skip,
    input  logic [4:0]         cfg_pix_off,
    input  logic [LVL_W-1:0]   fifo_level,
    output logic               bus_req,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [LEN_W-1:0]   bus_len,
    input  logic               bus_ack,
    output logic               beat_valid,
    output logic [ADDR_W-1:0]  beat_addr,
    output logic               sof,
    output logic [4:0]         pix_off,
    output logic               busy
);
    logic [ADDR_W-1:0]  act_base, nxt_base, walk_addr;
    logic [LINE_W-1:0]  act_line;
    logic [FRAME_W-1:0] act_frame;
    logic [SKIP_W-1:0]  act_skip;
    logic               last_word, step, restart, frame_wrap, apply;

    assign apply = restart | frame_wrap;

    fb2d_shadow #(
        .ADDR_W(ADDR_W), .LINE_W(LINE_W), .FRAME_W(FRAME_W), .SKIP_W(SKIP_W)
    ) u_shadow (
        .clk(clk), .rst_n(rst_n), .upd(cfg_update), .apply(apply),
        .in_base(cfg_base), .in_line(cfg_line_words), .in_frame(cfg_frame_words),
        .in_skip(cfg_skip), .in_off(cfg_pix_off),
        .act_base(act_base), .act_line(act_line), .act_frame(act_frame),
        .act_skip(act_skip), .act_off(pix_off), .nxt_base(nxt_base)
    );

    fb2d_walker #(
        .ADDR_W(ADDR_W), .LINE_W(LINE_W), .FRAME_W(FRAME_W), .SKIP_W(SKIP_W)
    ) u_walker (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(step),
        .base_nxt(nxt_base), .line_words(act_line), .frame_words(act_frame),
        .skip(act_skip), .addr(walk_addr), .last_word(last_word)
    );

    fb2d_burst_fsm #(
        .BURST(BURST), .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fifo_level(fifo_level),
        .bus_ack(bus_ack), .last_word(last_word), .bus_req(bus_req),
        .beat_valid(beat_valid), .step(step), .restart(restart),
        .busy(busy), .frame_wrap(frame_wrap)
    );

    assign bus_addr  = walk_addr;
    assign beat_addr = walk_addr;
    assign bus_len   = LEN_W'(BURST - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sof <= 1'b0;
        else        sof <= apply;
    end

    // R4: an unanswered request holds with the same address
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));
    // R5: beats start only after an accepted request
    p_beat_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beat_valid) |-> $past(bus_req && bus_ack));
    // R7: a frame start places the walker on the active base
    p_sof_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (beat_addr == (act_base & ~ADDR_W'(3))));
endmodule

// File: tb/fb2d_fetch_tb.sv
module fb2d_fetch_tb;
    localparam int THRESH = 512 - (2 * 8 + 3);
    localparam int WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable, cfg_update, bus_ack;
    logic [31:0] cfg_base;
    logic [11:0] cfg_line_words;
    logic [19:0] cfg_frame_words;
    logic [15:0] cfg_skip;
    logic [4:0]  cfg_pix_off;
    logic [9:0]  fifo_level;
    logic        bus_req, beat_valid, sof, busy;
    logic [31:0] bus_addr, beat_addr;
    logic [2:0]  bus_len;
    logic [4:0]  pix_off;

    always #10 clk = ~clk;

    fb2d_fetch u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_update(cfg_update),
        .cfg_base(cfg_base), .cfg_line_words(cfg_line_words),
        .cfg_frame_words(cfg_frame_words), .cfg_skip(cfg_skip),
        .cfg_pix_off(cfg_pix_off), .fifo_level(fifo_level), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_len(bus_len), .bus_ack(bus_ack),
        .beat_valid(beat_valid), .beat_addr(beat_addr), .sof(sof),
        .pix_off(pix_off), .busy(busy)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit wd_hit = 0;

    // reference model of the active and shadow configuration and the walk
    logic [31:0] m_addr, m_base, s_base, prev_baddr;
    int m_lw, m_fw, m_skip, m_off, m_line, m_frame;
    int s_lw, s_fw, s_skip, s_off;
    bit m_pend, exp_sof, stop_exp, exp_idle, exp_busy;
    bit prev_beat, prev_req, prev_ack;
    int prev_lvl, beat_idx;
    string kind;
    bit q_upd;
    logic [31:0] q_base;
    int q_lw, q_fw, q_skip, q_off;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] walign(input logic [31:0] a);
        return a & 32'hFFFF_FFFC;
    endfunction

    task automatic do_apply();
        if (m_pend) begin
            m_base = s_base; m_lw = s_lw; m_fw = s_fw; m_skip = s_skip; m_off = s_off;
            m_pend = 0;
        end
    endtask

    task automatic model_step(input bit en);
        if (m_frame + 1 == m_fw) begin
            do_apply();
            m_addr = walign(m_base); m_line = 0; m_frame = 0;
            exp_sof = 1;
            if (!en) stop_exp = 1;
            kind = "R7 wrap address";
        end else if (m_line + 1 == m_lw) begin
            m_addr = walign(m_addr + 32'd4 + 32'(m_skip));
            m_line = 0; m_frame++;
            kind = "R6 line skip address";
        end else begin
            m_addr = m_addr + 32'd4; m_line++; m_frame++;
            kind = "R5 word address";
        end
    endtask

    task automatic one_cycle(input bit en, input bit allow_upd, input bit lvl_high);
        bit starting;
        int lvl;
        @(negedge clk);
        cyc++;
        if (cyc > WD_LIMIT) wd_hit = 1;
        // checks of what the last edge produced
        chk(sof == exp_sof, "R7 sof pulse", 32'(sof), 32'(exp_sof));
        exp_sof = 0;
        chk(pix_off == 5'(m_off), "R8 active pix_off", 32'(pix_off), 32'(m_off));
        if (exp_idle) begin chk(busy == 1'b0, "R9 stop after frame end", 32'(busy), 0); exp_idle = 0; end
        if (exp_busy) begin chk(busy == 1'b1, "R2 busy after start", 32'(busy), 1); exp_busy = 0; end
        if (!busy) chk(!bus_req && !beat_valid, "R9 idle quiet", {bus_req, beat_valid}, 0);
        if (prev_ack) chk(beat_valid && !bus_req, "R5 beats follow ack", {bus_req, beat_valid}, 1);
        if (bus_req) begin
            chk(bus_len == 3'd7, "R4 burst length field", 32'(bus_len), 7);
            chk(bus_addr == m_addr, "R5 burst start address", bus_addr, m_addr);
            if (prev_req && !prev_ack) chk(bus_addr == prev_baddr, "R4 request hold", bus_addr, prev_baddr);
            if (!prev_req) chk(prev_lvl < THRESH, "R3 request threshold", 32'(prev_lvl), THRESH);
        end
        // drive inputs for the coming edge
        enable = en;
        starting = !busy && en;
        bus_ack = bus_req ? 1'($urandom_range(0, 1)) : 1'b0;
        lvl = lvl_high ? $urandom_range(THRESH, 512) : $urandom_range(0, 511);
        fifo_level = 10'(lvl);
        cfg_update = 1'b0;
        if (allow_upd && !beat_valid && !starting && (q_upd || $urandom_range(0, 29) == 0)) begin
            if (!q_upd) begin
                q_base = $urandom; q_lw = $urandom_range(2, 10); q_fw = $urandom_range(5, 60);
                q_skip = $urandom_range(0, 40); q_off = $urandom_range(0, 31);
            end
            q_upd = 0;
            cfg_base = q_base; cfg_line_words = 12'(q_lw); cfg_frame_words = 20'(q_fw);
            cfg_skip = 16'(q_skip); cfg_pix_off = 5'(q_off); cfg_update = 1'b1;
            s_base = q_base; s_lw = q_lw; s_fw = q_fw; s_skip = q_skip; s_off = q_off;
            m_pend = 1;
        end
        // model what the coming edge does
        if (beat_valid) begin
            chk(beat_addr == m_addr, kind, beat_addr, m_addr);
            beat_idx++;
            model_step(en);
            if (beat_idx == 8 && stop_exp) begin exp_idle = 1; stop_exp = 0; end
        end else if (prev_beat) begin
            chk(beat_idx == 8, "R5 beats per burst", 32'(beat_idx), 8);
            beat_idx = 0;
        end
        if (starting) begin
            do_apply();
            m_addr = walign(m_base); m_line = 0; m_frame = 0;
            exp_sof = 1; exp_busy = 1;
            kind = "R2 first address at aligned base";
        end
        prev_beat = beat_valid; prev_req = bus_req; prev_ack = bus_ack;
        prev_baddr = bus_addr; prev_lvl = lvl;
    endtask

    task automatic run(input int n, input bit allow_upd);
        for (int i = 0; i < n && !wd_hit; i++)
            one_cycle(1'b1, allow_upd, (i % 200) < 20);
    endtask

    task automatic stop_and_wait();
        int k = 0;
        one_cycle(1'b0, 1'b0, 1'b0);
        while ((busy || exp_idle) && k < 3000 && !wd_hit) begin
            one_cycle(1'b0, 1'b0, 1'b0);
            k++;
        end
        chk(busy == 1'b0, "R9 busy falls after stop", 32'(busy), 0);
        chk(stop_exp == 0, "R9 stop at frame end", 32'(stop_exp), 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_2D0F));
        rst_n = 0; enable = 0; cfg_update = 0; bus_ack = 0; fifo_level = '0;
        cfg_base = '0; cfg_line_words = '0; cfg_frame_words = '0; cfg_skip = '0; cfg_pix_off = '0;
        m_addr = 0; m_base = 0; s_base = 0; prev_baddr = 0;
        m_lw = 0; m_fw = 0; m_skip = 0; m_off = 0; m_line = 0; m_frame = 0;
        s_lw = 0; s_fw = 0; s_skip = 0; s_off = 0;
        m_pend = 0; exp_sof = 0; stop_exp = 0; exp_idle = 0; exp_busy = 0;
        prev_beat = 0; prev_req = 0; prev_ack = 0; prev_lvl = 0; beat_idx = 0;
        kind = "R5 word address"; q_upd = 0; q_base = 0; q_lw = 0; q_fw = 0; q_skip = 0; q_off = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1 busy after reset", 32'(busy), 0);
        chk(bus_req == 0, "R1 bus_req after reset", 32'(bus_req), 0);
        chk(beat_valid == 0, "R1 beat_valid after reset", 32'(beat_valid), 0);
        chk(sof == 0 && pix_off == 0, "R1 sof and pix_off after reset", {sof, pix_off}, 0);

        // directed: unaligned base, frame not a multiple of the line, odd skip
        q_upd = 1; q_base = 32'h0000_1003; q_lw = 4; q_fw = 10; q_skip = 6; q_off = 13;
        one_cycle(1'b0, 1'b1, 1'b0);
        one_cycle(1'b0, 1'b0, 1'b0);
        chk(pix_off == 5'd0, "R8 shadow not active before start", 32'(pix_off), 0);
        run(400, 1'b0);
        // R3 directed: FIFO near full keeps requests back
        for (int i = 0; i < 60 && !wd_hit; i++) one_cycle(1'b1, 1'b0, 1'b1);
        // R8 directed: update mid-run takes effect only at the wrap
        q_upd = 1; q_base = 32'h0002_0000; q_lw = 3; q_fw = 7; q_skip = 16; q_off = 31;
        run(400, 1'b1);
        stop_and_wait();

        for (int ep = 0; ep < 7 && !wd_hit; ep++) begin
            q_upd = 1; q_base = $urandom; q_lw = $urandom_range(2, 10);
            q_fw = $urandom_range(5, 60); q_skip = $urandom_range(0, 40); q_off = $urandom_range(0, 31);
            one_cycle(1'b0, 1'b1, 1'b0);
            run(2000, 1'b1);
            stop_and_wait();
        end

        if (wd_hit) begin
            errors++; checks++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, WD_LIMIT);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule